// File: doc/BRIEF.md
# Adapter Interrupt Indicator Setter

This block turns a message-signalled interrupt write into updates of adapter-interrupt indicator bits in memory. The 32-bit write data holds a function identifier in its upper part and a vector number in its low byte. The identifier is looked up in a table of per-function entries. Each entry names an indicator byte array (base address and bit offset), a summary byte array (base address and bit offset) and a 3-bit interruption subclass. For a match, the block sets one indicator bit and then one summary bit. Each bit is set by a read-modify-write OR on a single byte-wide memory port that the block owns.

An I/O interrupt word is emitted only when the summary byte read back as zero before the OR. That way a burst of messages to functions that share a summary byte raises one interrupt. A write whose identifier matches no valid entry leaves memory untouched and raises an error event that carries the vector number. Reads of the control region return all ones.

A table-load port fills entries at any time. The block takes one message at a time and shows `busy` while it is working.

Top module: `msi_ind_setter`

## Requirements
- R1: The function identifier is `wr_data[31:8]` and the vector number is `wr_data[7:0]`.
- R2: The lookup matches only entries whose valid flag is set. When several valid entries carry the same identifier, the lowest index wins. An entry rewritten with its valid flag clear stops matching.
- R3: The indicator bit position p is the entry's indicator offset plus the vector. The byte written is at indicator base + p/8, and the mask is 8'h80 >> (p mod 8).
- R4: The summary bit is placed by the same rule, using the summary base and the summary offset.
- R5: Each bit set is an atomic OR. A read of a byte is followed on the very next cycle by a write to the same address. The write data is the byte returned by that read (one cycle read latency) ORed with the mask.
- R6: The indicator write completes before the summary read is issued. A matched message makes exactly four memory cycles.
- R7: `irq_valid` pulses for one cycle only when the summary byte read as 8'h00. It is due on the fifth rising edge after the edge that accepts the message. `irq_word` is the subclass shifted left by 27, ORed with 32'h1.
- R8: An unmatched identifier makes no memory access. `err_valid` pulses for one cycle on the first edge after acceptance, with `err_fid` set to the identifier and `err_qual` set to the vector shifted left by 8.
- R9: `busy` is high from the accepting edge until the sequence ends. A message offered while busy is ignored.
- R10: A read of the control region (`rd_en`) gives `rd_valid` on the next cycle with `rd_data` = 32'hFFFFFFFF.
- R11: After reset `busy`, `irq_valid`, `err_valid`, `mem_req` and `rd_valid` are low and no table entry matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write one table entry |
| cfg_idx | input | 5 | Entry index |
| cfg_valid | input | 1 | Valid flag for the entry |
| cfg_fid | input | 24 | Function identifier |
| cfg_ind_base | input | 16 | Indicator array byte address |
| cfg_ind_off | input | 16 | Indicator bit offset |
| cfg_sum_base | input | 16 | Summary array byte address |
| cfg_sum_off | input | 16 | Summary bit offset |
| cfg_isc | input | 3 | Interruption subclass |
| wr_valid | input | 1 | Message write strobe |
| wr_data | input | 32 | Message write data |
| busy | output | 1 | Sequence in progress |
| rd_en | input | 1 | Control region read strobe |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| mem_req | output | 1 | Memory access |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Byte read, valid the cycle after the read |
| irq_valid | output | 1 | Interrupt request pulse |
| irq_word | output | 32 | Interrupt word |
| err_valid | output | 1 | Error event pulse |
| err_fid | output | 24 | Identifier that missed |
| err_qual | output | 32 | Error qualifier holding the vector |

## Verification
The bench offers each message on one edge and then samples 1 ns after each of the following six rising edges. It records the edge on which `irq_valid` or `err_valid` is high and the number of edges on which `mem_req` is high. A matched message must give its interrupt on edge 5 (or none) after exactly four memory cycles. A miss must give its error on edge 1 with no memory cycle. Indicator and summary bytes are compared in the bench's memory model once the sequence ends, against addresses and masks the bench derives from its own copy of the table. The read strobe is checked on the single edge after it is applied.

// File: rtl/msi_ind_pkg.sv
package msi_ind_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_LOOK   = 3'd1,
    ST_IND_RD = 3'd2,
    ST_IND_WR = 3'd3,
    ST_SUM_RD = 3'd4,
    ST_SUM_WR = 3'd5
  } seq_state_e;

  localparam int unsigned ISC_SHIFT  = 27;
  localparam int unsigned QUAL_SHIFT = 8;
endpackage

// File: rtl/msi_ind_table.sv
module msi_ind_table #(
  parameter int unsigned NUM    = 32,
  parameter int unsigned FID_W  = 24,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned ISC_W  = 3,
  localparam int unsigned IDX_W = $clog2(NUM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_valid,
  input  logic [FID_W-1:0]  cfg_fid,
  input  logic [ADDR_W-1:0] cfg_ind_base,
  input  logic [OFF_W-1:0]  cfg_ind_off,
  input  logic [ADDR_W-1:0] cfg_sum_base,
  input  logic [OFF_W-1:0]  cfg_sum_off,
  input  logic [ISC_W-1:0]  cfg_isc,
  input  logic [FID_W-1:0]  look_fid,
  output logic              hit,
  output logic [ADDR_W-1:0] hit_ind_base,
  output logic [OFF_W-1:0]  hit_ind_off,
  output logic [ADDR_W-1:0] hit_sum_base,
  output logic [OFF_W-1:0]  hit_sum_off,
  output logic [ISC_W-1:0]  hit_isc
);
  logic [NUM-1:0]    vld_q;
  logic [FID_W-1:0]  fid_q  [NUM];
  logic [ADDR_W-1:0] ibase_q[NUM];
  logic [OFF_W-1:0]  ioff_q [NUM];
  logic [ADDR_W-1:0] sbase_q[NUM];
  logic [OFF_W-1:0]  soff_q [NUM];
  logic [ISC_W-1:0]  isc_q  [NUM];
  logic [NUM-1:0]    match;

  for (genvar i = 0; i < NUM; i++) begin : g_ent
    logic ent_en;
    assign ent_en   = cfg_we && (cfg_idx == IDX_W'(i));
    assign match[i] = vld_q[i] && (fid_q[i] == look_fid);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q[i] <= 1'b0;
      else if (ent_en) vld_q[i] <= cfg_valid;
    end

    always_ff @(posedge clk) begin
      if (ent_en) begin
        fid_q[i]   <= cfg_fid;
        ibase_q[i] <= cfg_ind_base;
        ioff_q[i]  <= cfg_ind_off;
        sbase_q[i] <= cfg_sum_base;
        soff_q[i]  <= cfg_sum_off;
        isc_q[i]   <= cfg_isc;
      end
    end
  end

  // Walk from the top down so that the lowest matching index is the one kept.
  always_comb begin
    hit          = |match;
    hit_ind_base = '0;
    hit_ind_off  = '0;
    hit_sum_base = '0;
    hit_sum_off  = '0;
    hit_isc      = '0;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_ind_base = ibase_q[i];
        hit_ind_off  = ioff_q[i];
        hit_sum_base = sbase_q[i];
        hit_sum_off  = soff_q[i];
        hit_isc      = isc_q[i];
      end
    end
  end

  // R2: a hit must come from an entry whose valid flag is set
  assert_hit_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (vld_q != '0));
endmodule

// File: rtl/msi_ind_seq.sv
module msi_ind_seq
  import msi_ind_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned ISC_W  = 3,
  localparam int unsigned FID_W = DATA_W - VEC_W,
  localparam int unsigned POS_W = OFF_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic [FID_W-1:0]  look_fid,
  input  logic              hit,
  input  logic [ADDR_W-1:0] hit_ind_base,
  input  logic [OFF_W-1:0]  hit_ind_off,
  input  logic [ADDR_W-1:0] hit_sum_base,
  input  logic [OFF_W-1:0]  hit_sum_off,
  input  logic [ISC_W-1:0]  hit_isc,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              irq_valid,
  output logic [31:0]       irq_word,
  output logic              err_valid,
  output logic [FID_W-1:0]  err_fid,
  output logic [31:0]       err_qual
);
  seq_state_e        st_q, st_d;
  logic [FID_W-1:0]  fid_q;
  logic [VEC_W-1:0]  vec_q;
  logic [ADDR_W-1:0] iaddr_q, saddr_q, iaddr_d, saddr_d;
  logic [7:0]        imask_q, smask_q, imask_d, smask_d;
  logic [ISC_W-1:0]  isc_q;
  logic              irq_q, irq_d, err_q, err_d;
  logic              take_req, take_loc;
  logic [POS_W-1:0]  ipos, spos;

  assign take_req = (st_q == ST_IDLE) && wr_valid;
  assign take_loc = (st_q == ST_LOOK) && hit;
  assign look_fid = fid_q;

  // Byte address and MSB-first mask of each bit to set
  always_comb begin
    ipos    = POS_W'(hit_ind_off) + POS_W'(vec_q);
    spos    = POS_W'(hit_sum_off);
    iaddr_d = hit_ind_base + ADDR_W'(ipos >> 3);
    saddr_d = hit_sum_base + ADDR_W'(spos >> 3);
    imask_d = 8'h80 >> ipos[2:0];
    smask_d = 8'h80 >> spos[2:0];
  end

  always_comb begin
    st_d  = st_q;
    irq_d = 1'b0;
    err_d = 1'b0;
    unique case (st_q)
      ST_IDLE:   if (wr_valid) st_d = ST_LOOK;
      ST_LOOK:   if (hit) st_d = ST_IND_RD;
                 else begin st_d = ST_IDLE; err_d = 1'b1; end
      ST_IND_RD: st_d = ST_IND_WR;
      ST_IND_WR: st_d = ST_SUM_RD;
      ST_SUM_RD: st_d = ST_SUM_WR;
      ST_SUM_WR: begin st_d = ST_IDLE; irq_d = (mem_rdata == 8'h00); end
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      irq_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      irq_q <= irq_d;
      err_q <= err_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take_req) begin
      fid_q <= wr_data[DATA_W-1:VEC_W];
      vec_q <= wr_data[VEC_W-1:0];
    end
    if (take_loc) begin
      iaddr_q <= iaddr_d;
      saddr_q <= saddr_d;
      imask_q <= imask_d;
      smask_q <= smask_d;
      isc_q   <= hit_isc;
    end
  end

  always_comb begin
    mem_req   = (st_q == ST_IND_RD) || (st_q == ST_IND_WR) ||
                (st_q == ST_SUM_RD) || (st_q == ST_SUM_WR);
    mem_we    = (st_q == ST_IND_WR) || (st_q == ST_SUM_WR);
    mem_addr  = ((st_q == ST_SUM_RD) || (st_q == ST_SUM_WR)) ? saddr_q : iaddr_q;
    mem_wdata = mem_rdata | ((st_q == ST_SUM_WR) ? smask_q : imask_q);
  end

  assign busy      = (st_q != ST_IDLE);
  assign irq_valid = irq_q;
  assign irq_word  = (32'(isc_q) << ISC_SHIFT) | 32'h1;
  assign err_valid = err_q;
  assign err_fid   = fid_q;
  assign err_qual  = 32'(vec_q) << QUAL_SHIFT;

  // R5: every write follows a read of the same byte on the previous cycle
  assert_rmw_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> ($past(mem_req && !mem_we) && $past(mem_addr) == mem_addr));
  // R5: the write only adds a single bit to the byte read
  assert_or_one_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (((mem_wdata & mem_rdata) == mem_rdata) &&
                             ($countones(mem_wdata ^ mem_rdata) <= 1)));
  // R6: a summary read is only issued right after a write
  assert_ind_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_SUM_RD) |-> $past(mem_req && mem_we));
  // R7: an interrupt only follows a write whose byte read back as zero
  assert_irq_on_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> $past(mem_req && mem_we && mem_rdata == 8'h00));
  // R8: error events are one-cycle pulses, never alongside an interrupt
  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> !err_valid);
  assert_err_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_valid && irq_valid));
endmodule

// File: rtl/msi_ind_setter.sv
module msi_ind_setter #(
  parameter int unsigned NUM    = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned ISC_W  = 3,
  localparam int unsigned FID_W = DATA_W - VEC_W,
  localparam int unsigned IDX_W = $clog2(NUM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_valid,
  input  logic [FID_W-1:0]  cfg_fid,
  input  logic [ADDR_W-1:0] cfg_ind_base,
  input  logic [OFF_W-1:0]  cfg_ind_off,
  input  logic [ADDR_W-1:0] cfg_sum_base,
  input  logic [OFF_W-1:0]  cfg_sum_off,
  input  logic [ISC_W-1:0]  cfg_isc,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  input  logic              rd_en,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              irq_valid,
  output logic [31:0]       irq_word,
  output logic              err_valid,
  output logic [FID_W-1:0]  err_fid,
  output logic [31:0]       err_qual
);
  logic [FID_W-1:0]  look_fid;
  logic              hit;
  logic [ADDR_W-1:0] h_ibase, h_sbase;
  logic [OFF_W-1:0]  h_ioff, h_soff;
  logic [ISC_W-1:0]  h_isc;
  logic              rd_q;

  msi_ind_table #(
    .NUM(NUM), .FID_W(FID_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .ISC_W(ISC_W)
  ) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_fid(cfg_fid),
    .cfg_ind_base(cfg_ind_base), .cfg_ind_off(cfg_ind_off),
    .cfg_sum_base(cfg_sum_base), .cfg_sum_off(cfg_sum_off), .cfg_isc(cfg_isc),
    .look_fid(look_fid), .hit(hit),
    .hit_ind_base(h_ibase), .hit_ind_off(h_ioff),
    .hit_sum_base(h_sbase), .hit_sum_off(h_soff), .hit_isc(h_isc)
  );

  msi_ind_seq #(
    .DATA_W(DATA_W), .VEC_W(VEC_W), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .ISC_W(ISC_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_data(wr_data), .busy(busy),
    .look_fid(look_fid), .hit(hit),
    .hit_ind_base(h_ibase), .hit_ind_off(h_ioff),
    .hit_sum_base(h_sbase), .hit_sum_off(h_soff), .hit_isc(h_isc),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .irq_valid(irq_valid), .irq_word(irq_word),
    .err_valid(err_valid), .err_fid(err_fid), .err_qual(err_qual)
  );

  // Control region read: all ones, one cycle after the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 1'b0;
    else rd_q <= rd_en;
  end

  assign rd_valid = rd_q;
  assign rd_data  = rd_q ? 32'hFFFF_FFFF : 32'h0;

  // R10: read data follows the strobe by one cycle
  assert_rd_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_en) |-> (rd_valid && rd_data == 32'hFFFF_FFFF));
endmodule

// File: tb/sim_msi_ind_setter.sv
module sim_msi_ind_setter;
  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic        cfg_we, cfg_valid;
  logic [4:0]  cfg_idx;
  logic [23:0] cfg_fid;
  logic [15:0] cfg_ind_base, cfg_ind_off, cfg_sum_base, cfg_sum_off;
  logic [2:0]  cfg_isc;
  logic        wr_valid, busy, rd_en, rd_valid;
  logic [31:0] wr_data, rd_data, irq_word, err_qual;
  logic        mem_req, mem_we, irq_valid, err_valid;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [23:0] err_fid;

  msi_ind_setter u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_valid(cfg_valid), .cfg_fid(cfg_fid),
    .cfg_ind_base(cfg_ind_base), .cfg_ind_off(cfg_ind_off),
    .cfg_sum_base(cfg_sum_base), .cfg_sum_off(cfg_sum_off), .cfg_isc(cfg_isc),
    .wr_valid(wr_valid), .wr_data(wr_data), .busy(busy),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .irq_valid(irq_valid), .irq_word(irq_word),
    .err_valid(err_valid), .err_fid(err_fid), .err_qual(err_qual)
  );

  // Byte memory with one-cycle read latency
  logic [7:0] mem [0:1023];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] <= 8'h00;
      mem_rdata <= 8'h00;
    end else if (mem_req) begin
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:0]];
    end
  end

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Bench copy of the table
  logic        t_vld  [32];
  logic [23:0] t_fid  [32];
  logic [15:0] t_ib [32], t_io [32], t_sb [32], t_so [32];
  logic [2:0]  t_isc  [32];

  task automatic load(input int idx, input bit v, input logic [23:0] f,
                      input logic [15:0] ib, io, sb, so, input logic [2:0] isc);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 5'(idx); cfg_valid = v; cfg_fid = f;
    cfg_ind_base = ib; cfg_ind_off = io; cfg_sum_base = sb; cfg_sum_off = so; cfg_isc = isc;
    @(negedge clk);
    cfg_we = 0;
    t_vld[idx] = v; t_fid[idx] = f; t_ib[idx] = ib; t_io[idx] = io;
    t_sb[idx] = sb; t_so[idx] = so; t_isc[idx] = isc;
  endtask

  function automatic int find(input logic [23:0] f);
    for (int i = 0; i < 32; i++) if (t_vld[i] && t_fid[i] == f) return i;
    return -1;
  endfunction

  int irq_k, err_k, req_n;
  logic [31:0] irq_w, eq;
  logic [23:0] ef;

  task automatic watch();
    irq_k = 0; err_k = 0; req_n = 0;
    for (int k = 1; k <= 6; k++) begin
      @(posedge clk); #1;
      if (mem_req) req_n++;
      if (irq_valid && irq_k == 0) begin irq_k = k; irq_w = irq_word; end
      if (err_valid && err_k == 0) begin err_k = k; ef = err_fid; eq = err_qual; end
    end
  endtask

  // One message with full expected-result checking
  task automatic run_msg(input logic [31:0] d, input bit exp_hit);
    logic [23:0] f;
    logic [7:0]  v, m_i, m_s, pre_i, pre_s;
    logic [16:0] pi, ps;
    logic [15:0] a_i, a_s;
    int e;
    f = d[31:8]; v = d[7:0];   // R1 split
    e = find(f);
    chk((e >= 0) == exp_hit, "R2", "table lookup in bench", 32'(e), 32'(exp_hit));
    if (e >= 0) begin
      pi = 17'(t_io[e]) + 17'(v); ps = 17'(t_so[e]);
      a_i = t_ib[e] + 16'(pi >> 3); a_s = t_sb[e] + 16'(ps >> 3);
      m_i = 8'h80 >> pi[2:0]; m_s = 8'h80 >> ps[2:0];
      pre_i = mem[a_i[9:0]]; pre_s = mem[a_s[9:0]];
    end
    @(negedge clk); wr_valid = 1; wr_data = d;
    @(posedge clk); #1; wr_valid = 0;
    chk(busy, "R9", "busy after accept", 32'(busy), 32'h1);
    watch();
    chk(!busy, "R9", "idle after sequence", 32'(busy), 32'h0);
    if (e >= 0) begin
      chk(err_k == 0, "R8", "no error on hit", 32'(err_k), 32'h0);
      chk(req_n == 4, "R6", "memory cycles on hit", 32'(req_n), 32'd4);
      chk(mem[a_i[9:0]] == (pre_i | m_i), "R3", "indicator byte",
          32'(mem[a_i[9:0]]), 32'(pre_i | m_i));
      chk(mem[a_s[9:0]] == (pre_s | m_s), "R4", "summary byte",
          32'(mem[a_s[9:0]]), 32'(pre_s | m_s));
      if (pre_s == 8'h00) begin
        chk(irq_k == 5, "R7", "interrupt edge", 32'(irq_k), 32'd5);
        chk(irq_w == ((32'(t_isc[e]) << 27) | 32'h1), "R7", "interrupt word",
            irq_w, (32'(t_isc[e]) << 27) | 32'h1);
      end else
        chk(irq_k == 0, "R7", "no interrupt on nonzero summary", 32'(irq_k), 32'h0);
    end else begin
      chk(req_n == 0, "R8", "no memory access on miss", 32'(req_n), 32'h0);
      chk(irq_k == 0, "R8", "no interrupt on miss", 32'(irq_k), 32'h0);
      chk(err_k == 1, "R8", "error edge", 32'(err_k), 32'd1);
      chk(ef == f, "R8", "error identifier", 32'(ef), 32'(f));
      chk(eq == (32'(v) << 8), "R8", "error qualifier", eq, 32'(v) << 8);
    end
  endtask

  // Stimulus vectors: {expected hit, write data}
  localparam int NV = 8;
  localparam logic [32:0] VT [NV] = '{
    {1'b1, 24'h000005, 8'h00},
    {1'b1, 24'h000005, 8'h09},
    {1'b1, 24'h000007, 8'h03},
    {1'b1, 24'h123456, 8'hFF},
    {1'b0, 24'h000009, 8'h11},
    {1'b0, 24'hABCDEF, 8'h22},
    {1'b1, 24'h000007, 8'h00},
    {1'b1, 24'h123456, 8'h00}
  };

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) t_vld[i] = 0;
    rst_n = 0; cfg_we = 0; cfg_idx = 0; cfg_valid = 0; cfg_fid = 0;
    cfg_ind_base = 0; cfg_ind_off = 0; cfg_sum_base = 0; cfg_sum_off = 0; cfg_isc = 0;
    wr_valid = 0; wr_data = 0; rd_en = 0;
    repeat (4) @(posedge clk);
    #1;
    // R11 reset state
    chk(!busy && !irq_valid && !err_valid && !mem_req && !rd_valid, "R11", "outputs in reset",
        {27'b0, busy, irq_valid, err_valid, mem_req, rd_valid}, 32'h0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk(!busy && !mem_req, "R11", "outputs after release", {30'b0, busy, mem_req}, 32'h0);

    // R11: an empty table matches nothing
    run_msg({24'h000005, 8'h01}, 1'b0);

    load(0,  1, 24'h000005, 16'h0100, 16'd0,  16'h0200, 16'd0, 3'd3);
    load(1,  1, 24'h000007, 16'h0110, 16'd13, 16'h0200, 16'd1, 3'd6);
    load(2,  0, 24'h000009, 16'h0300, 16'd0,  16'h0300, 16'd0, 3'd2);
    load(3,  1, 24'h000007, 16'h0180, 16'd0,  16'h0280, 16'd0, 3'd5); // R2 duplicate, lower index wins
    load(31, 1, 24'h123456, 16'h0120, 16'd5,  16'h0210, 16'd9, 3'd1);

    for (int n = 0; n < NV; n++) run_msg(VT[n][31:0], VT[n][32]);

    // R2: the duplicate at index 3 must not have been touched
    chk(mem[10'h180] == 8'h00, "R2", "lower index wins", 32'(mem[10'h180]), 32'h0);

    // R9: a message offered while busy is ignored
    @(negedge clk); wr_valid = 1; wr_data = {24'h000005, 8'h10};
    @(posedge clk); #1; wr_data = {24'h000005, 8'h28};
    @(posedge clk); #1; wr_valid = 0;
    repeat (6) @(posedge clk); #1;
    chk(mem[10'h102] == 8'h80, "R9", "accepted message applied", 32'(mem[10'h102]), 32'h80);
    chk(mem[10'h105] == 8'h00, "R9", "busy message ignored", 32'(mem[10'h105]), 32'h0);

    // R10: control region read
    @(negedge clk); rd_en = 1;
    @(posedge clk); #1; rd_en = 0;
    chk(rd_valid && rd_data == 32'hFFFF_FFFF, "R10", "read data", rd_data, 32'hFFFF_FFFF);
    @(posedge clk); #1;
    chk(!rd_valid, "R10", "read valid is one cycle", 32'(rd_valid), 32'h0);

    // R2: clearing the valid flag stops the match
    load(0, 0, 24'h000005, 16'h0100, 16'd0, 16'h0200, 16'd0, 3'd3);
    run_msg({24'h000005, 8'h33}, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule